// File: doc/BRIEF.md
# Serial LED Bus Initiator

This block is the host end of a four-wire enclosure-management link toward a drive backplane. From a fast system clock it makes a slow serial clock, a load line that marks the start of each frame, and a data-out stream. The data-out stream carries three indicator bits per drive slot. The load line also carries a four-bit vendor code right after the frame start. While it sends, the block samples the data-in line that the backplane drives. From it the block keeps a presence bit for each drive and decides whether a backplane is attached at all.

The host gives the block the request vectors (activity, locate, fail), the vendor code, a drive count and a clock-divider value. A mode input picks continuous streaming or on-demand frames. In on-demand mode a frame goes out only when the indicator request differs from the copy that was sent last. Between frames the serial clock rests high.

Top module: `ledbus_initiator`

## Requirements
- R1: During and right after reset, sclk is 1, sload is 0, sdout is 0, drive_present is all zeros and bp_present is 0.
- R2: While a frame runs, each half period of sclk lasts half_div+1 system clocks. Outside a frame, sclk stays at 1.
- R3: Each frame begins with exactly five serial clock cycles in which sload and sdout are 0. The first data cycle then has sload at 1.
- R4: In data cycles 1 to 4, sload carries vendor bits 0, 1, 2 and 3 in that order.
- R5: Data cycle 3d+p carries, for drive d, activity (p=0), then locate (p=1), then fail (p=2). All values are latched when the frame begins.
- R6: A frame has max(3n, 6) data cycles, and the cycles after the last drive carry 0. n is drive_count, with 0 taken as 1 and values above MAX_DRIVES taken as MAX_DRIVES.
- R7: The data-in value at the rising sclk edge of drive d's first bit is stored in drive_present[d]. The other bits of drive_present keep their value.
- R8: At the last rising sclk edge of a frame, bp_present becomes 1 if any second or third bit of a drive group was sampled as 0 in that frame, and 0 otherwise.
- R9: In continuous mode (cont_mode=1), a new frame follows the previous one at once, without any idle time.
- R10: In on-demand mode, a frame starts only when {act_req, loc_req, fail_req} differs from the values latched for the last frame. Otherwise the bus stays idle with sclk=1 and sload=0.
- R11: sload and sdout change only in the system clock in which sclk falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req | input | MAX_DRIVES | Activity request per drive |
| loc_req | input | MAX_DRIVES | Locate request per drive |
| fail_req | input | MAX_DRIVES | Fail request per drive |
| vendor | input | 4 | Vendor code sent on the load line |
| drive_count | input | $clog2(MAX_DRIVES+1) | Number of drive groups per frame |
| half_div | input | DIV_W | Half period of the serial clock, minus one, in system clocks |
| cont_mode | input | 1 | 1 selects continuous frames, 0 selects on-demand frames |
| sdin | input | 1 | Serial data from the backplane |
| sclk | output | 1 | Serial clock |
| sload | output | 1 | Frame start and vendor code line |
| sdout | output | 1 | Serial indicator data |
| drive_present | output | MAX_DRIVES | Sampled presence bit per drive |
| bp_present | output | 1 | Backplane detected in the last finished frame |

## Verification
Two events can fall on one rising serial edge: the sample of the last drive group, which decides bp_present and can update drive_present, and the decision whether to start the next frame. A change of the request vectors can land on that same edge. The bench changes the request vectors and the mode at arbitrary clocks while the data-in line toggles pseudo-randomly, so changes do land on frame ends. A behavioural model recomputes every output on every clock. It judges whether the closing status and the restart, or the fall to idle, both took effect in the same system clock.

// File: rtl/ledbus_initiator.sv
module ledbus_initiator #(
  parameter int MAX_DRIVES = 36,
  parameter int DIV_W = 16,
  localparam int DRV_W = $clog2(MAX_DRIVES + 1),
  localparam int CYC_W = $clog2(3 * MAX_DRIVES + 7)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MAX_DRIVES-1:0] act_req,
  input  logic [MAX_DRIVES-1:0] loc_req,
  input  logic [MAX_DRIVES-1:0] fail_req,
  input  logic [3:0]            vendor,
  input  logic [DRV_W-1:0]      drive_count,
  input  logic [DIV_W-1:0]      half_div,
  input  logic                  cont_mode,
  input  logic                  sdin,
  output logic                  sclk,
  output logic                  sload,
  output logic                  sdout,
  output logic [MAX_DRIVES-1:0] drive_present,
  output logic                  bp_present
);
  typedef enum logic [1:0] {IDLE, PRE, DATA} st_t;

  st_t                  st;
  logic [DIV_W-1:0]     tick;
  logic [CYC_W-1:0]     cyc, last_s, n3, last_in;
  logic [DRV_W-1:0]     drv, n_s, n_in;
  logic [1:0]           pos;
  logic [MAX_DRIVES-1:0] act_s, loc_s, fail_s;
  logic [3:0]           vendor_s;
  logic                 bp_acc, acc_nxt;
  logic                 go, edge_ev, falling, rising, in_data, last_cyc, latch;
  logic                 bit_val, load_val;
  logic                 is_idle, frame_first;

  always_comb begin
    if (drive_count == '0) n_in = DRV_W'(1);
    else if (drive_count > DRV_W'(MAX_DRIVES)) n_in = DRV_W'(MAX_DRIVES);
    else n_in = drive_count;
  end

  assign n3      = CYC_W'(n_in) + CYC_W'(n_in) + CYC_W'(n_in);
  assign last_in = (n3 > CYC_W'(6)) ? n3 - CYC_W'(1) : CYC_W'(5);

  assign go       = cont_mode || ({act_req, loc_req, fail_req} != {act_s, loc_s, fail_s});
  assign edge_ev  = (st != IDLE) && (tick >= half_div);
  assign falling  = edge_ev && sclk;
  assign rising   = edge_ev && !sclk;
  assign in_data  = (st == DATA) && (drv < n_s);
  assign last_cyc = (st == DATA) && (cyc == last_s);
  assign latch    = ((st == IDLE) && go) || (rising && last_cyc && go);
  assign acc_nxt  = bp_acc | (in_data && (pos != 2'd0) && !sdin);

  assign is_idle     = (st == IDLE);
  assign frame_first = (st == DATA) && (cyc == '0);

  always_comb begin
    case (pos)
      2'd0:    bit_val = act_s[drv];
      2'd1:    bit_val = loc_s[drv];
      default: bit_val = fail_s[drv];
    endcase
  end

  always_comb begin
    if (cyc == '0) load_val = 1'b1;
    else if (cyc <= CYC_W'(4)) load_val = vendor_s[2'(cyc - CYC_W'(1))];
    else load_val = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_s <= '0; loc_s <= '0; fail_s <= '0;
      vendor_s <= '0; n_s <= DRV_W'(1); last_s <= CYC_W'(5);
      bp_acc <= 1'b0;
    end else if (latch) begin
      act_s <= act_req; loc_s <= loc_req; fail_s <= fail_req;
      vendor_s <= vendor; n_s <= n_in; last_s <= last_in;
      bp_acc <= 1'b0;
    end else if (rising && in_data) begin
      bp_acc <= acc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; tick <= '0; cyc <= '0; drv <= '0; pos <= '0;
      sclk <= 1'b1; sload <= 1'b0; sdout <= 1'b0;
      drive_present <= '0; bp_present <= 1'b0;
    end else if (st == IDLE) begin
      tick <= '0;
      if (go) begin
        st  <= PRE;
        cyc <= '0;
      end
    end else if (edge_ev) begin
      tick <= '0;
      if (falling) begin
        sclk  <= 1'b0;
        sload <= (st == DATA) ? load_val : 1'b0;
        sdout <= in_data ? bit_val : 1'b0;
      end else begin
        sclk <= 1'b1;
        if (in_data && pos == 2'd0) drive_present[drv] <= sdin;
        if (st == PRE) begin
          if (cyc == CYC_W'(4)) begin
            st <= DATA; cyc <= '0; drv <= '0; pos <= '0;
          end else begin
            cyc <= cyc + CYC_W'(1);
          end
        end else if (last_cyc) begin
          bp_present <= acc_nxt;
          cyc <= '0;
          st  <= go ? PRE : IDLE;
        end else begin
          cyc <= cyc + CYC_W'(1);
          if (pos == 2'd2) begin
            pos <= 2'd0;
            drv <= drv + DRV_W'(1);
          end else begin
            pos <= pos + 2'd1;
          end
        end
      end
    end else begin
      tick <= tick + DIV_W'(1);
    end
  end
endmodule

// File: rtl/ledbus_initiator_chk.sv
module ledbus_initiator_chk #(
  parameter int MAX_DRIVES = 36,
  parameter int DIV_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sclk,
  input logic                  sload,
  input logic                  sdout,
  input logic [MAX_DRIVES-1:0] drive_present,
  input logic                  bp_present,
  input logic [DIV_W-1:0]      half_div,
  input logic                  is_idle,
  input logic                  frame_first
);
  logic [2:0] lowcnt;
  logic       sclk_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowcnt <= '0;
      sclk_p <= 1'b1;
    end else begin
      sclk_p <= sclk;
      if (sclk && !sclk_p)
        lowcnt <= sload ? 3'd0 : ((lowcnt == 3'd7) ? 3'd7 : lowcnt + 3'd1);
    end
  end

  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (half_div != '0 && !$stable(sclk)) |=> $stable(sclk));

  a_r3_gap_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_first && $rose(sload)) |-> (lowcnt >= 3'd5));

  a_r7_present_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_present) |-> $rose(sclk));

  a_r8_bp_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_present) |-> $rose(sclk));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> (sclk && !sload));

  a_r11_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sload) || !$stable(sdout)) |-> $fell(sclk));
endmodule

bind ledbus_initiator ledbus_initiator_chk #(.MAX_DRIVES(MAX_DRIVES), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sload(sload), .sdout(sdout),
  .drive_present(drive_present), .bp_present(bp_present), .half_div(half_div),
  .is_idle(is_idle), .frame_first(frame_first)
);

// File: tb/ledbus_initiator_tb.sv
module ledbus_initiator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD = 36;
  localparam int DW = 16;
  localparam int CW = $clog2(MAXD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [MAXD-1:0] act_req = '0, loc_req = '0, fail_req = '0;
  logic [3:0] vendor = '0;
  logic [CW-1:0] drive_count = CW'(4);
  logic [DW-1:0] half_div = DW'(1);
  logic cont_mode = 1'b1, sdin = 1'b1;
  logic sclk, sload, sdout, bp_present;
  logic [MAXD-1:0] drive_present;

  int n_cmp = 0, n_bad = 0;
  int sd_mode = 0;
  logic [15:0] lf = 16'hACE1;

  ledbus_initiator #(.MAX_DRIVES(MAXD), .DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .loc_req(loc_req), .fail_req(fail_req),
    .vendor(vendor), .drive_count(drive_count), .half_div(half_div), .cont_mode(cont_mode),
    .sdin(sdin), .sclk(sclk), .sload(sload), .sdout(sdout),
    .drive_present(drive_present), .bp_present(bp_present));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int lq[$], dq[$], kq[$];
  int m_i, m_t, m_frames = 0;
  bit m_busy, m_sclk = 1, m_load, m_dout, m_bp, m_acc;
  logic [MAXD-1:0] m_pres = '0, m_sa = '0, m_sl = '0, m_sf = '0;

  function automatic bit req_diff();
    return {act_req, loc_req, fail_req} != {m_sa, m_sl, m_sf};
  endfunction

  task automatic build();
    int n, len;
    n = (drive_count == 0) ? 1 : ((int'(drive_count) > MAXD) ? MAXD : int'(drive_count));
    m_sa = act_req; m_sl = loc_req; m_sf = fail_req;
    lq.delete(); dq.delete(); kq.delete();
    for (int i = 0; i < 5; i++) begin lq.push_back(0); dq.push_back(0); kq.push_back(-1); end
    len = (3 * n > 6) ? 3 * n : 6;
    for (int c = 0; c < len; c++) begin
      int d, p;
      d = c / 3; p = c % 3;
      lq.push_back(c == 0 ? 1 : (c <= 4 ? int'(vendor[c-1]) : 0));
      if (d < n) begin
        dq.push_back(p == 0 ? int'(m_sa[d]) : (p == 1 ? int'(m_sl[d]) : int'(m_sf[d])));
        kq.push_back(p == 0 ? d : -2);
      end else begin
        dq.push_back(0); kq.push_back(-1);
      end
    end
    m_i = 0; m_acc = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sclk = 1; m_load = 0; m_dout = 0; m_pres = '0; m_bp = 0;
      m_sa = '0; m_sl = '0; m_sf = '0; m_t = 0;
    end else if (!m_busy) begin
      if (cont_mode || req_diff()) begin build(); m_busy = 1; m_t = 0; end
    end else if (m_t >= int'(half_div)) begin
      m_t = 0;
      if (m_sclk) begin
        m_sclk = 0; m_load = lq[m_i][0]; m_dout = dq[m_i][0];
      end else begin
        int k;
        m_sclk = 1;
        k = kq[m_i];
        if (k >= 0) m_pres[k] = sdin;
        else if (k == -2 && !sdin) m_acc = 1;
        m_i++;
        if (m_i == lq.size()) begin
          m_bp = m_acc;
          m_frames++;
          if (cont_mode || req_diff()) build();
          else m_busy = 0;
        end
      end
    end else begin
      m_t++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and side monitors
  int hi_run = 0, max_hi = 0, viol = 0;
  bit pscl = 1, pld = 0, pdo = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(sclk == m_sclk, "R2 sclk", 64'(sclk), 64'(m_sclk));
        chk(sload == m_load, "R3/R4 sload", 64'(sload), 64'(m_load));
        chk(sdout == m_dout, "R5/R6 sdout", 64'(sdout), 64'(m_dout));
        chk(drive_present == m_pres, "R7 drive_present", 64'(drive_present), 64'(m_pres));
        chk(bp_present == m_bp, "R8 bp_present", 64'(bp_present), 64'(m_bp));
        hi_run = sclk ? hi_run + 1 : 0;
        if (hi_run > max_hi) max_hi = hi_run;
        if ((sload != pld || sdout != pdo) && !(pscl && !sclk)) viol++;
      end
      pscl = sclk; pld = sload; pdo = sdout;
    end
  end

  // data-in driver
  initial begin
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sdin = (sd_mode == 0) ? 1'b1 : ((sd_mode == 1) ? 1'b0 : lf[0]);
    end
  end

  task automatic wait_frames(input int k);
    int target;
    target = m_frames + k;
    while (m_frames < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic randomize_req();
    act_req  = MAXD'({$urandom(), $urandom()});
    loc_req  = MAXD'({$urandom(), $urandom()});
    fail_req = MAXD'({$urandom(), $urandom()});
    vendor   = 4'($urandom());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    randomize_req();
    repeat (3) @(negedge clk);
    chk(sclk == 1 && sload == 0 && sdout == 0, "R1 line reset", {61'b0, sclk, sload, sdout}, 64'h4);
    chk(drive_present == '0 && bp_present == 0, "R1 status reset", 64'(drive_present), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1 && sload == 0 && sdout == 0, "R1 after release", {61'b0, sclk, sload, sdout}, 64'h4);

    // continuous, no target
    wait_frames(3);
    chk(drive_present[3:0] == 4'hF, "R7 all high", 64'(drive_present[3:0]), 64'hF);
    chk(bp_present == 0, "R8 no target", 64'(bp_present), 64'h0);

    // target pulling everything low
    sd_mode = 1;
    wait_frames(2);
    chk(drive_present[3:0] == 4'h0, "R7 all low", 64'(drive_present[3:0]), 64'h0);
    chk(bp_present == 1, "R8 target seen", 64'(bp_present), 64'h1);

    // long frames, toggling data-in, requests changing mid-frame
    sd_mode = 2;
    drive_count = CW'(36);
    max_hi = 0;
    for (int r = 0; r < 4; r++) begin
      repeat (150 + r * 97) @(negedge clk);
      randomize_req();
    end
    wait_frames(2);
    chk(max_hi <= int'(half_div) + 1, "R9 no idle in continuous", 64'(max_hi), 64'(half_div + 1));

    // clamping of the drive count
    sd_mode = 0;
    drive_count = CW'(50);
    wait_frames(2);
    chk(drive_present == {MAXD{1'b1}}, "R6 count clamped to max", 64'(drive_present), 64'({MAXD{1'b1}}));
    drive_count = CW'(0);
    randomize_req();
    wait_frames(2);
    drive_count = CW'(2);
    sd_mode = 2;
    wait_frames(2);

    // on-demand mode
    cont_mode = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    begin
      int quiet = 1, f0;
      f0 = m_frames;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (!(sclk && !sload)) quiet = 0;
      end
      chk(quiet == 1, "R10 idle while unchanged", 64'(quiet), 64'h1);
      act_req[1] = ~act_req[1];
      @(negedge clk);
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(m_frames == f0 + 1, "R10 one frame per change", 64'(m_frames), 64'(f0 + 1));
      chk(sclk == 1, "R2 idle high", 64'(sclk), 64'h1);
    end
    half_div = DW'(0);
    loc_req = ~loc_req;
    @(negedge clk);
    while (m_busy) @(negedge clk);
    half_div = DW'(3);
    drive_count = CW'(5);
    fail_req = ~fail_req;
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (10) @(negedge clk);

    chk(viol == 0, "R11 changes only on falling edge", 64'(viol), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule